// File: doc/BRIEF.md
# Single-Accumulator Execution Unit

This block executes one-address instructions against a single accumulator register. Each instruction names one memory location. The accumulator is the implicit second source and also the destination. There are three operations. Load copies a memory word into the accumulator. Add sums a memory word into the accumulator. Store writes the accumulator back to memory.

Instructions arrive over a valid/ready handshake. The unit drives a synchronous data memory port whose read data appears one cycle after the read request. It also keeps a zero flag and a carry flag that reflect the last arithmetic or load result.

An external sequencer feeds instructions such as Load A, Add B, Store C, and the unit leaves A+B at C. Instruction fetch, program counting and branching belong to the surrounding logic.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, the accumulator, zero flag and carry flag read 0 and `instr_ready` is 1.
- R2: The opcode field `instr_op` is encoded as follows: 2'b00 Load, 2'b01 Add, 2'b10 Store, 2'b11 illegal. An instruction is accepted in a cycle where `instr_valid` and `instr_ready` are both high.
- R3: In the cycle it accepts a Load or Add, the unit raises `mem_rd_en` with `mem_addr` equal to `instr_addr`. In the next cycle `instr_ready` is low and the returned word is captured. The new accumulator value is visible from the cycle after that.
- R4: Load places the read word in the accumulator. It sets the zero flag exactly when that word is 0 and leaves the carry flag unchanged.
- R5: Add places (accumulator + word) mod 2^DW in the accumulator. It sets the carry flag to the carry out of bit DW-1 and sets the zero flag exactly when the result is 0.
- R6: Store completes in its accept cycle. It raises `mem_wr_en` with `mem_addr` equal to `instr_addr` and `mem_wdata` equal to the accumulator, and it leaves the accumulator and both flags unchanged.
- R7: An illegal opcode is accepted in one cycle. `illegal_op` is high in that cycle only, no memory access is made, and the accumulator and flags are left unchanged.
- R8: Load A, Add B, Store C issued back to back leaves A+B (mod 2^DW) at location C. A Store that directly follows an Add writes the updated sum.
- R9: No more than one of `mem_rd_en`, `mem_wr_en` and `illegal_op` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_op | input | 2 | Operation code |
| instr_addr | input | AW | Explicit memory operand address |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, one cycle after request |
| acc_out | output | DW | Accumulator value |
| flag_zero | output | 1 | Zero status |
| flag_carry | output | 1 | Carry status |
| illegal_op | output | 1 | Pulse on acceptance of an unknown opcode |

## Verification
The main function is driven with several instruction streams:
- A plain Load/Add/Store chain, which shows that the operand flows through memory and the accumulator.
- An Add whose sum overflows to a non-zero value, and an Add whose sum wraps exactly to zero, which separate the carry flag from the zero flag.
- A Load of zero placed after a carrying Add, which proves that Load touches only the zero flag.
- An illegal opcode dropped between legal instructions, which shows that it disturbs neither memory nor the accumulator.

The bench models the accumulator and flags cycle by cycle and compares them on every clock, so an update one cycle early or late is caught.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_ADD   = 2'b01,
        OP_STORE = 2'b10,
        OP_BAD   = 2'b11
    } acc_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic bad;
        logic is_add;
    } dec_t;

    function automatic dec_t decode_op(input logic fire, input logic [1:0] op);
        dec_t d;
        d.rd     = fire && (op == OP_LOAD || op == OP_ADD);
        d.wr     = fire && (op == OP_STORE);
        d.bad    = fire && (op == OP_BAD);
        d.is_add = (op == OP_ADD);
        return d;
    endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic       fire,
    input  logic [1:0] op,
    output dec_t       dec
);
    always_comb dec = decode_op(fire, op);
endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_rd,
    input  logic start_add,
    output logic ready,
    output logic wb_en,
    output logic wb_add
);
    seq_state_e state;
    logic       pend_add;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pend_add <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start_rd) begin
                    state    <= ST_WAIT;
                    pend_add <= start_add;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ready  = (state == ST_IDLE);
    assign wb_en  = (state == ST_WAIT);
    assign wb_add = pend_add;
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wb_en,
    input  logic          wb_add,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] acc,
    output logic          zero,
    output logic          carry
);
    logic [DW:0]   sum_ext;
    logic [DW-1:0] next_val;

    always_comb begin
        sum_ext  = {1'b0, acc} + {1'b0, rdata};
        next_val = wb_add ? sum_ext[DW-1:0] : rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            zero  <= 1'b0;
            carry <= 1'b0;
        end else if (wb_en) begin
            acc  <= next_val;
            zero <= (next_val == '0);
            if (wb_add) carry <= sum_ext[DW];
        end
    end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_valid,
    output logic          instr_ready,
    input  logic [1:0]    instr_op,
    input  logic [AW-1:0] instr_addr,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] acc_out,
    output logic          flag_zero,
    output logic          flag_carry,
    output logic          illegal_op
);
    logic fire;
    dec_t dec;
    logic wb_en, wb_add;

    assign fire = instr_valid && instr_ready;

    acc_decode u_dec (
        .fire (fire),
        .op   (instr_op),
        .dec  (dec)
    );

    acc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_rd  (dec.rd),
        .start_add (dec.is_add),
        .ready     (instr_ready),
        .wb_en     (wb_en),
        .wb_add    (wb_add)
    );

    acc_datapath #(.DW(DW)) u_dp (
        .clk   (clk),
        .rst   (rst),
        .wb_en (wb_en),
        .wb_add(wb_add),
        .rdata (mem_rdata),
        .acc   (acc_out),
        .zero  (flag_zero),
        .carry (flag_carry)
    );

    assign mem_rd_en  = dec.rd;
    assign mem_wr_en  = dec.wr;
    assign illegal_op = dec.bad;
    assign mem_addr   = instr_addr;
    assign mem_wdata  = acc_out;
endmodule

// File: rtl/acc_exec_checker.sv
module acc_exec_checker #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          instr_valid,
    input logic          instr_ready,
    input logic [1:0]    instr_op,
    input logic [AW-1:0] instr_addr,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] acc_out,
    input logic          flag_zero,
    input logic          flag_carry,
    input logic          illegal_op
);
    logic acc_load, acc_add;
    assign acc_load = instr_valid && instr_ready && instr_op == 2'b00;
    assign acc_add  = instr_valid && instr_ready && instr_op == 2'b01;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && !flag_zero && !flag_carry && instr_ready));

    assert_wait_stall_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_load || acc_add) |=> !instr_ready);

    assert_load_value_R4: assert property (@(posedge clk) disable iff (rst)
        acc_load |=> ##1 (acc_out == $past(mem_rdata) && flag_carry == $past(flag_carry, 2)));

    assert_add_zero_R5: assert property (@(posedge clk) disable iff (rst)
        acc_add |=> ##1 (flag_zero == (acc_out == '0)));

    assert_store_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> ($stable(acc_out) && $stable(flag_zero) && $stable(flag_carry)));

    assert_bad_inert_R7: assert property (@(posedge clk) disable iff (rst)
        illegal_op |=> ($stable(acc_out) && $stable(flag_zero) && $stable(flag_carry)));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd_en, mem_wr_en, illegal_op}));
endmodule

bind acc_exec_unit acc_exec_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_valid(instr_valid),
    .instr_ready(instr_ready),
    .instr_op   (instr_op),
    .instr_addr (instr_addr),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_rdata  (mem_rdata),
    .acc_out    (acc_out),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .illegal_op (illegal_op)
);

// File: tb/test_acc_exec_unit.sv
module test_acc_exec_unit;
    localparam int DW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_valid = 1'b0;
    logic          instr_ready;
    logic [1:0]    instr_op = 2'b00;
    logic [AW-1:0] instr_addr = '0;
    logic          mem_rd_en, mem_wr_en, illegal_op;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] acc_out;
    logic          flag_zero, flag_carry;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit mon_on = 0;

    int exp_acc = 0;
    bit exp_z = 0;
    bit exp_c = 0;

    logic [DW-1:0] mem [2**AW];

    always #2.5 clk = ~clk;

    acc_exec_unit #(.DW(DW), .AW(AW)) i_acc_exec_unit (
        .clk(clk), .rst(rst),
        .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_op(instr_op), .instr_addr(instr_addr),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_out(acc_out), .flag_zero(flag_zero), .flag_carry(flag_carry),
        .illegal_op(illegal_op)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Per-clock comparison of accumulator state against the model (R3, R4, R5)
    always @(negedge clk) begin
        if (mon_on && !done) begin
            chk(int'(acc_out) == exp_acc, "R3/R4/R5", "acc", int'(acc_out), exp_acc);
            chk(flag_zero == exp_z, "R4/R5", "zero", int'(flag_zero), int'(exp_z));
            chk(flag_carry == exp_c, "R4/R5", "carry", int'(flag_carry), int'(exp_c));
        end
    end

    task automatic run(input logic [1:0] op, input int addr);
        int v;
        int s;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_op    = op;
        instr_addr  = AW'(addr);
        #0.5;
        chk(instr_ready == 1'b1, "R2", "ready at issue", int'(instr_ready), 1);
        chk(illegal_op == (op == 2'b11), "R7", "illegal pulse", int'(illegal_op), int'(op == 2'b11));
        chk(mem_rd_en == (op < 2'b10), "R3", "read enable", int'(mem_rd_en), int'(op < 2'b10));
        chk(mem_wr_en == (op == 2'b10), "R6", "write enable", int'(mem_wr_en), int'(op == 2'b10));
        chk(int'(mem_addr) == addr, "R3", "address", int'(mem_addr), addr);
        if (op == 2'b10)
            chk(int'(mem_wdata) == exp_acc, "R6", "write data", int'(mem_wdata), exp_acc);
        v = int'(mem[addr]);
        @(posedge clk);
        #0.5;
        instr_valid = 1'b0;
        if (op < 2'b10) begin
            @(negedge clk);
            chk(instr_ready == 1'b0, "R3", "ready in wait", int'(instr_ready), 0);
            @(posedge clk);
            #0.5;
            if (op == 2'b00) begin
                exp_acc = v;
            end else begin
                s = exp_acc + v;
                exp_c = (s >= 2**DW);
                exp_acc = s % (2**DW);
            end
            exp_z = (exp_acc == 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 2**AW; i++) mem[i] = '0;
        mem[1] = 8'd25;  mem[2] = 8'd17;  mem[3] = 8'd200; mem[4] = 8'd100;
        mem[5] = 8'd128; mem[6] = 8'd0;   mem[7] = 8'd60;  mem[9] = 8'd99;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(acc_out == '0, "R1", "reset acc", int'(acc_out), 0);
        chk(!flag_zero && !flag_carry, "R1", "reset flags", int'({flag_zero, flag_carry}), 0);
        chk(instr_ready, "R1", "reset ready", int'(instr_ready), 1);
        rst = 1'b0;
        mon_on = 1;

        // R8: Load A, Add B, Store C
        run(2'b00, 1); run(2'b01, 2); run(2'b10, 9);
        @(negedge clk);
        chk(mem[9] == 8'd42, "R8", "sum stored", int'(mem[9]), 42);

        // R5: non-zero overflow sets carry
        run(2'b00, 3); run(2'b01, 4); run(2'b10, 10);
        @(negedge clk);
        chk(mem[10] == 8'd44, "R6", "stored wrap", int'(mem[10]), 44);

        // R4: load of zero keeps carry set
        run(2'b00, 6);

        // R5: wrap to exactly zero
        run(2'b00, 5); run(2'b01, 5);

        // R7: illegal opcode leaves memory alone
        run(2'b11, 9);
        @(negedge clk);
        chk(mem[9] == 8'd42, "R7", "memory untouched", int'(mem[9]), 42);
        chk(!illegal_op, "R7", "pulse ended", int'(illegal_op), 0);

        // R8: second chain, carry cleared
        run(2'b00, 7); run(2'b01, 1); run(2'b10, 11);
        @(negedge clk);
        chk(mem[11] == 8'd85, "R8", "second sum", int'(mem[11]), 85);

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule